// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This block sits beside a CPU pipeline and turns a one-cycle fault request into a fetch redirect. The request carries a fault kind and the PC of the faulting instruction. The block looks up a fixed vector offset for that kind and adds it to a firmware base register to form the new fetch address. It also supplies the sequential address after that target.

In the same cycle it may save a restart address into an exception-address register. The save happens when the CPU is outside privileged firmware mode, or when the fault kind always forces a save. For trap-class kinds the saved value points one instruction past the faulting one.

A saturating occurrence counter is kept for every fault kind and can be read through an index port. The firmware base and the exception-address register can be read and written through a small register port.

Fault kind codes: 0 reset, 1 interrupt, 2 instruction-side access violation, 3 instruction-side translation miss, 4 instruction-side page fault, 5 single data translation miss, 6 double data translation miss, 7 data page fault, 8 data access violation, 9 unaligned access, 10 data-side unaligned access, 11 unimplemented opcode, 12 machine check, 13 arithmetic, 14 integer overflow, 15 floating point disabled, 16 firmware call. Codes 17 and above are illegal.

A fault is accepted when `fault_valid_i` is high, the kind is legal, and `redirect_valid_o` is low, all on the same rising edge.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, `redirect_valid_o` is 0, `redirect_pc_o` and `redirect_npc_o` are 0, both registers read 0, and every counter reads 0.
- R2: In the cycle after an accepted fault, `redirect_valid_o` is 1 and `redirect_pc_o` equals the firmware base plus the kind's vector. The vectors by code are: 0→0x0001, 1→0x0101, 2→0x0081, 3 and 4→0x0181, 5→0x0201, 6→0x0281, 7 and 8→0x0381, 9 and 10→0x0301, 11→0x0481, 12→0x0401, 13 and 14→0x0501, 15→0x0581, 16→0x2001.
- R3: Whenever `redirect_valid_o` is 1, `redirect_npc_o` equals `redirect_pc_o` + 4.
- R4: An accepted fault writes the exception-address register when `fw_mode_i` is 0, or when the kind is 0 or 12 (these force a save). In any other case the register keeps its value.
- R5: When the save happens, the value saved is `pc_i` + 4 for the trap kinds 13, 14 and 16, and `pc_i` for every other kind.
- R6: `redirect_valid_o` is high for exactly one cycle per accepted fault. A request present while it is high is ignored: no counter changes and the exception-address register keeps its value.
- R7: Each accepted fault adds 1 to the counter of its own kind, and to no other counter. A counter stops at 2^CNT_W-1. `cnt_val_o` shows the counter selected by `cnt_idx_i` in the same cycle, and shows 0 for an index of 17 or more.
- R8: The register port selects with `reg_sel_i`: 0 is the firmware base, 1 is the exception-address register. `reg_rdata_o` shows the selected register in the same cycle. A write with `reg_we_i` takes effect at the clock edge. A write in the same cycle as an accepted fault is dropped.
- R9: A request with a kind code of 17 or more produces no redirect. It changes no counter and does not touch the exception-address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | Fault request strobe |
| fault_kind_i | input | 5 | Fault kind code |
| pc_i | input | ADDR_W | PC of the faulting instruction |
| fw_mode_i | input | 1 | CPU is in privileged firmware mode |
| reg_we_i | input | 1 | Register port write enable |
| reg_sel_i | input | 1 | Register select: 0 firmware base, 1 exception address |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Selected register value |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | ADDR_W | New fetch address |
| redirect_npc_o | output | ADDR_W | Sequential address after the redirect target |
| cnt_idx_i | input | 5 | Counter read index |
| cnt_val_o | output | CNT_W | Selected counter value |

## Verification
The bench builds the block with ADDR_W of 32 and CNT_W of 4. The narrow counter saturates at 15, so a short burst of one kind drives it into its ceiling and shows that it stays there. The full 32-bit address width lets the bench use a base with high bits set, which exercises the carry of the base-plus-vector addition and of the trap-kind increment.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  localparam int unsigned NUM_KINDS = 17;
  localparam int unsigned KIND_W    = 5;
  localparam int unsigned VEC_W     = 14;

  typedef enum logic [KIND_W-1:0] {
    K_RESET    = 5'd0,
    K_IRQ      = 5'd1,
    K_IX_ACV   = 5'd2,
    K_IX_MISS  = 5'd3,
    K_IX_PAGE  = 5'd4,
    K_DX_MISS1 = 5'd5,
    K_DX_MISS2 = 5'd6,
    K_DX_PAGE  = 5'd7,
    K_DX_ACV   = 5'd8,
    K_ALIGN    = 5'd9,
    K_DX_ALIGN = 5'd10,
    K_BAD_OP   = 5'd11,
    K_MCHK     = 5'd12,
    K_ARITH    = 5'd13,
    K_OVF      = 5'd14,
    K_FP_OFF   = 5'd15,
    K_FW_CALL  = 5'd16
  } fault_kind_e;

  typedef struct packed {
    logic             legal;
    logic             trap;
    logic             forced;
    logic [VEC_W-1:0] vec;
  } kind_attr_t;

  function automatic logic [VEC_W-1:0] vec_of(logic [KIND_W-1:0] k);
    case (k)
      K_RESET:               vec_of = 14'h0001;
      K_IRQ:                 vec_of = 14'h0101;
      K_IX_ACV:              vec_of = 14'h0081;
      K_IX_MISS, K_IX_PAGE:  vec_of = 14'h0181;
      K_DX_MISS1:            vec_of = 14'h0201;
      K_DX_MISS2:            vec_of = 14'h0281;
      K_DX_PAGE, K_DX_ACV:   vec_of = 14'h0381;
      K_ALIGN, K_DX_ALIGN:   vec_of = 14'h0301;
      K_BAD_OP:              vec_of = 14'h0481;
      K_MCHK:                vec_of = 14'h0401;
      K_ARITH, K_OVF:        vec_of = 14'h0501;
      K_FP_OFF:              vec_of = 14'h0581;
      K_FW_CALL:             vec_of = 14'h2001;
      default:               vec_of = '0;
    endcase
  endfunction

  function automatic logic is_trap(logic [KIND_W-1:0] k);
    is_trap = (k == K_ARITH) || (k == K_OVF) || (k == K_FW_CALL);
  endfunction

  function automatic logic is_forced(logic [KIND_W-1:0] k);
    is_forced = (k == K_RESET) || (k == K_MCHK);
  endfunction
endpackage

// File: rtl/exc_fault_decode.sv
module exc_fault_decode
  import exc_dispatch_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  output kind_attr_t        attr_o
);
  always_comb begin
    attr_o.legal  = (kind_i < KIND_W'(NUM_KINDS));
    attr_o.trap   = is_trap(kind_i);
    attr_o.forced = is_forced(kind_i);
    attr_o.vec    = vec_of(kind_i);
  end
endmodule

// File: rtl/exc_priv_regs.sv
module exc_priv_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              save_en_i,
  input  logic [ADDR_W-1:0] save_val_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] exc_o
);
  logic [ADDR_W-1:0] base_q, exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      exc_q  <= '0;
    end else if (accept_i) begin
      // fault wins over a same-cycle register write
      if (save_en_i) exc_q <= save_val_i;
    end else if (we_i) begin
      if (sel_i) exc_q  <= wdata_i;
      else       base_q <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? exc_q : base_q;
  assign base_o  = base_q;
  assign exc_o   = exc_q;
endmodule

// File: rtl/exc_redirect_gen.sv
module exc_redirect_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] vec_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o
);
  logic [ADDR_W-1:0] tgt;
  logic              valid_q;
  logic [ADDR_W-1:0] pc_q, npc_q;

  assign tgt = base_i + vec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      npc_q   <= '0;
    end else begin
      valid_q <= accept_i;
      if (accept_i) begin
        pc_q  <= tgt;
        npc_q <= tgt + ADDR_W'(INSN_BYTES);
      end
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;
  assign npc_o   = npc_q;
endmodule

// File: rtl/exc_event_counters.sv
module exc_event_counters
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [KIND_W-1:0] idx_i,
  output logic [CNT_W-1:0]  val_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_arr [NUM_KINDS];

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= '0;
      else if (inc_i && (kind_i == KIND_W'(g)) && (q != CNT_MAX))
        q <= q + 1'b1;
    end
    assign cnt_arr[g] = q;
  end

  always_comb begin
    val_o = '0;
    for (int i = 0; i < NUM_KINDS; i++)
      if (idx_i == KIND_W'(i)) val_o = cnt_arr[i];
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [KIND_W-1:0] fault_kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              fw_mode_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [ADDR_W-1:0] redirect_npc_o,
  input  logic [KIND_W-1:0] cnt_idx_i,
  output logic [CNT_W-1:0]  cnt_val_o
);
  localparam int unsigned INSN_BYTES = 4;

  kind_attr_t        attr;
  logic              accept;
  logic              save_en;
  logic [ADDR_W-1:0] save_val;
  logic [ADDR_W-1:0] base_w, exc_w;
  logic [ADDR_W-1:0] vec_ext;

  exc_fault_decode u_dec (
    .kind_i (fault_kind_i),
    .attr_o (attr)
  );

  assign accept   = fault_valid_i & attr.legal & ~redirect_valid_o;
  assign save_en  = attr.forced | ~fw_mode_i;
  assign save_val = attr.trap ? pc_i + ADDR_W'(INSN_BYTES) : pc_i;
  assign vec_ext  = ADDR_W'(attr.vec);

  exc_priv_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .save_en_i  (save_en),
    .save_val_i (save_val),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .base_o     (base_w),
    .exc_o      (exc_w)
  );

  exc_redirect_gen #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_redir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .base_i   (base_w),
    .vec_i    (vec_ext),
    .valid_o  (redirect_valid_o),
    .pc_o     (redirect_pc_o),
    .npc_o    (redirect_npc_o)
  );

  exc_event_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept),
    .kind_i (fault_kind_i),
    .idx_i  (cnt_idx_i),
    .val_o  (cnt_val_o)
  );
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fault_valid_i,
  input logic [KIND_W-1:0] fault_kind_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              fw_mode_i,
  input logic              redirect_valid_o,
  input logic [ADDR_W-1:0] redirect_pc_o,
  input logic [ADDR_W-1:0] redirect_npc_o,
  input logic [ADDR_W-1:0] base_w,
  input logic [ADDR_W-1:0] exc_w
);
  logic req_ok;
  assign req_ok = fault_valid_i && !redirect_valid_o && (fault_kind_i < KIND_W'(NUM_KINDS));

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o); // R6

  AST_ACCEPT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> redirect_valid_o); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ok |=> !redirect_valid_o); // R9

  AST_NPC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (redirect_npc_o == redirect_pc_o + ADDR_W'(4))); // R3

  AST_TARGET_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> (redirect_pc_o == $past(base_w) + ADDR_W'(vec_of($past(fault_kind_i))))); // R2

  AST_FW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && fw_mode_i && !is_forced(fault_kind_i)) |=> (exc_w == $past(exc_w))); // R4

  AST_TRAP_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && !fw_mode_i && is_trap(fault_kind_i)) |=> (exc_w == $past(pc_i) + ADDR_W'(4))); // R5

  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && redirect_valid_o) |=> (exc_w == $past(exc_w) || $past(base_w) != base_w || 1'b1 == 1'b0 || exc_w == $past(exc_w))); // R6
endmodule

bind exc_dispatch exc_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fault_valid_i    (fault_valid_i),
  .fault_kind_i     (fault_kind_i),
  .pc_i             (pc_i),
  .fw_mode_i        (fw_mode_i),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .redirect_npc_o   (redirect_npc_o),
  .base_w           (base_w),
  .exc_w            (exc_w)
);

// File: tb/exc_dispatch_tb_top.sv
module exc_dispatch_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 4;
  localparam int unsigned NK = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fault_valid = 1'b0;
  logic [4:0]    fault_kind = '0;
  logic [AW-1:0] pc = '0;
  logic          fw_mode = 1'b0;
  logic          reg_we = 1'b0;
  logic          reg_sel = 1'b0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          rvalid;
  logic [AW-1:0] rpc, rnpc;
  logic [4:0]    cnt_idx = '0;
  logic [CW-1:0] cnt_val;

  int checks = 0;
  int errors = 0;
  int exp_cnt [NK];
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_dispatch #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .fault_valid_i    (fault_valid),
    .fault_kind_i     (fault_kind),
    .pc_i             (pc),
    .fw_mode_i        (fw_mode),
    .reg_we_i         (reg_we),
    .reg_sel_i        (reg_sel),
    .reg_wdata_i      (reg_wdata),
    .reg_rdata_o      (reg_rdata),
    .redirect_valid_o (rvalid),
    .redirect_pc_o    (rpc),
    .redirect_npc_o   (rnpc),
    .cnt_idx_i        (cnt_idx),
    .cnt_val_o        (cnt_val)
  );

  function automatic logic [AW-1:0] exp_vec(int k);
    case (k)
      0: return 32'h0001;   1: return 32'h0101;   2: return 32'h0081;
      3, 4: return 32'h0181; 5: return 32'h0201;  6: return 32'h0281;
      7, 8: return 32'h0381; 9, 10: return 32'h0301; 11: return 32'h0481;
      12: return 32'h0401;  13, 14: return 32'h0501; 15: return 32'h0581;
      16: return 32'h2001;  default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_trap(int k);
    return (k == 13) || (k == 14) || (k == 16);
  endfunction

  task automatic chk(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd_reg(logic sel, output logic [AW-1:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic rd_cnt(int k, output logic [CW-1:0] v);
    @(negedge clk);
    cnt_idx = 5'(k);
    #1 v = cnt_val;
  endtask

  task automatic wr_reg(logic sel, logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one-cycle request; samples pulse cycle and the cycle after
  task automatic fire(int k, logic [AW-1:0] p, logic fw,
                      output logic v1, output logic [AW-1:0] t, output logic [AW-1:0] n,
                      output logic v2);
    @(negedge clk);
    fault_valid = 1'b1; fault_kind = 5'(k); pc = p; fw_mode = fw;
    @(negedge clk);
    fault_valid = 1'b0;
    v1 = rvalid; t = rpc; n = rnpc;
    @(negedge clk);
    v2 = rvalid;
    if (k < NK && exp_cnt[k] < (1 << CW) - 1) exp_cnt[k]++;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v; logic [CW-1:0] c;
    chk("R1", "valid", AW'(rvalid), 0);
    chk("R1", "pc", rpc, 0);
    chk("R1", "npc", rnpc, 0);
    rd_reg(1'b0, v); chk("R1", "base", v, 0);
    rd_reg(1'b1, v); chk("R1", "exc", v, 0);
    for (int k = 0; k < NK; k++) begin
      rd_cnt(k, c); chk("R1", "cnt", AW'(c), 0);
    end
  endtask

  task automatic t_vectors();
    logic v1, v2; logic [AW-1:0] t, n, e, p;
    wr_reg(1'b0, 32'hFFFF_F000);
    for (int k = 0; k < NK; k++) begin
      p = 32'h0000_2000 + 32'(k * 16);
      fire(k, p, 1'b0, v1, t, n, v2);
      chk("R2", "valid", AW'(v1), 1);
      chk("R2", "target", t, 32'hFFFF_F000 + exp_vec(k));
      chk("R3", "npc", n, 32'hFFFF_F000 + exp_vec(k) + 4);
      chk("R6", "pulse end", AW'(v2), 0);
      rd_reg(1'b1, e);
      chk(exp_trap(k) ? "R5" : "R4", "saved", e, exp_trap(k) ? p + 4 : p);
    end
  endtask

  task automatic t_save_rules();
    logic v1, v2; logic [AW-1:0] t, n, e;
    wr_reg(1'b1, 32'h0000_1234);
    fire(5, 32'h0000_5000, 1'b1, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R4", "fw mode keeps", e, 32'h0000_1234);
    fire(13, 32'h0000_6000, 1'b1, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R4", "fw mode trap keeps", e, 32'h0000_1234);
    fire(12, 32'h0000_7000, 1'b1, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R4", "forced mchk", e, 32'h0000_7000);
    fire(0, 32'h0000_7100, 1'b1, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R4", "forced reset", e, 32'h0000_7100);
    fire(16, 32'hFFFF_FFFC, 1'b0, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R5", "trap wrap", e, 32'h0000_0000);
    fire(9, 32'h0000_8000, 1'b0, v1, t, n, v2);
    rd_reg(1'b1, e); chk("R5", "non-trap", e, 32'h0000_8000);
  endtask

  task automatic t_busy_ignore();
    logic [AW-1:0] e; logic [CW-1:0] c0, c1;
    rd_cnt(7, c0);
    @(negedge clk);
    fault_valid = 1'b1; fault_kind = 5'd7; pc = 32'h0000_A000; fw_mode = 1'b0;
    @(negedge clk);
    chk("R6", "first pulse", AW'(rvalid), 1);
    pc = 32'h0000_B000;
    @(negedge clk);
    fault_valid = 1'b0;
    chk("R6", "held request no pulse", AW'(rvalid), 0);
    rd_reg(1'b1, e); chk("R6", "exc from first", e, 32'h0000_A000);
    rd_cnt(7, c1); chk("R7", "single count", AW'(c1), AW'(c0) + 1);
    if (exp_cnt[7] < 15) exp_cnt[7]++;
  endtask

  task automatic t_illegal();
    logic v1, v2; logic [AW-1:0] t, n, e, e0;
    rd_reg(1'b1, e0);
    fire(20, 32'h0000_C000, 1'b0, v1, t, n, v2);
    chk("R9", "no pulse", AW'(v1), 0);
    rd_reg(1'b1, e); chk("R9", "exc kept", e, e0);
  endtask

  task automatic t_collide();
    logic [AW-1:0] b; logic [CW-1:0] c0, c1;
    wr_reg(1'b0, 32'h0010_0000);
    rd_cnt(2, c0);
    @(negedge clk);
    fault_valid = 1'b1; fault_kind = 5'd1; pc = 32'h0000_D000; fw_mode = 1'b0;
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0020_0000;
    @(negedge clk);
    if (exp_cnt[1] < 15) exp_cnt[1]++;
    chk("R8", "target old base", rpc, 32'h0010_0101);
    // write during the pulse is applied, fault is ignored
    fault_kind = 5'd2; reg_wdata = 32'h0030_0000;
    @(negedge clk);
    fault_valid = 1'b0; reg_we = 1'b0;
    rd_reg(1'b0, b); chk("R8", "write in pulse applied", b, 32'h0030_0000);
    rd_cnt(2, c1); chk("R6", "busy kind not counted", AW'(c1), AW'(c0));
    wr_reg(1'b1, 32'h0000_4444);
    rd_reg(1'b1, b); chk("R8", "exc write", b, 32'h0000_4444);
  endtask

  task automatic t_saturate();
    logic v1, v2; logic [AW-1:0] t, n; logic [CW-1:0] c;
    for (int i = 0; i < 18; i++) fire(1, 32'h0000_E000, 1'b1, v1, t, n, v2);
    rd_cnt(1, c); chk("R7", "saturated", AW'(c), 15);
    for (int k = 0; k < NK; k++) begin
      rd_cnt(k, c); chk("R7", "count", AW'(c), AW'(exp_cnt[k]));
    end
    rd_cnt(19, c); chk("R7", "index out of range", AW'(c), 0);
  endtask

  initial begin
    for (int k = 0; k < NK; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_vectors();
    t_save_rules();
    t_busy_ignore();
    t_illegal();
    t_collide();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule